// File: doc/BRIEF.md
# Ring Node Timeslot Bypass with Drop and Insert

This block sits on the byte-wide parallel side of a ring node in a time-division multiplexed backbone. One byte arrives per clock, one byte per timeslot, and a frame holds up to 2430 slots: one 8 kHz frame at a 19.44 Mbyte/s byte rate. An input frame pulse marks slot 0. A per-slot table, written by a CPU, gives each slot one of two treatments. A transit slot passes its byte to the parallel output after a single register stage. A local slot hands its byte to the station and refills the outgoing slot with the station's own data.

The station sees the current slot index as the byte arrives, so it can present its insert byte in the same cycle. The dropped byte and its slot index come out one cycle later, aligned with the parallel output. Local data goes only into slots the table marks as local, so inserted traffic never collides with transit traffic. Table writes go into a shadow copy. The shadow copy becomes active at the next input frame pulse, so no frame is ever switched under two different tables.

Top module: `ring_bypass_di`

## Requirements
- R1: In a transit slot, the output byte equals the received byte exactly one clock later.
- R2: The output frame pulse equals the input frame pulse delayed by one clock.
- R3: In a local slot, one clock after the byte arrives, dropValid is 1, dropData carries the received byte and dropSlot carries its slot index. In a transit slot, dropValid is 0 and dropData is 0x00.
- R4: In a local slot with insValid high, the output byte one clock later equals insData.
- R5: In a local slot with insValid low, the output byte one clock later is the idle byte 0xFF.
- R6: In a transit slot, insValid and insData have no effect on the output byte.
- R7: curSlot is 0 in a cycle with rxFrame high. Otherwise it is the previous slot plus one, and it wraps to 0 after slot NUM_SLOTS-1 even when no pulse comes.
- R8: A table write (cfgWrDrop=1 means local, 0 means transit) takes effect from the next cycle with rxFrame high, that cycle included. A write made in a pulse cycle waits for the pulse after it.
- R9: During reset, txData is 0xFF, txFrame is 0 and dropValid is 0. After reset, every slot is a transit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | DATA_W | Received byte of the current slot |
| rxFrame | input | 1 | High with the byte of slot 0 |
| txData | output | DATA_W | Outgoing parallel byte |
| txFrame | output | 1 | Outgoing frame pulse, aligned with txData |
| curSlot | output | SLOT_W | Slot index of the byte on rxData |
| insData | input | DATA_W | Station byte for slot curSlot |
| insValid | input | 1 | insData is valid this cycle |
| dropData | output | DATA_W | Byte taken off the ring for the station |
| dropValid | output | 1 | dropData is valid |
| dropSlot | output | SLOT_W | Slot index of dropData |
| cfgWrEn | input | 1 | Table write strobe |
| cfgWrSlot | input | SLOT_W | Slot to write |
| cfgWrDrop | input | 1 | 1 marks the slot local, 0 marks it transit |

## Verification
The bench runs a 12-slot configuration through full frames, a frame cut short by an early pulse, and a long stretch with no pulse. The last two catch a counter that either ignores the pulse or runs past the last slot. It rewrites the table in the middle of a frame and in the pulse cycle itself. A design that switched tables at once would split a frame, and one that took the pulse-cycle write would apply it a frame early. It toggles insValid on both transit and local slots, so it catches idle fill and insert that are mixed up or that leak into transit bytes.

// File: rtl/rbdi_pkg.sv
package rbdi_pkg;
  // Per-byte strobes handed from control to datapath.
  typedef struct packed {
    logic frame;   // this byte is slot 0
    logic drop;    // slot belongs to the local station
    logic useIns;  // local insert byte is valid for this slot
  } slot_strobe_t;
endpackage

// File: rtl/rbdi_ctrl.sv
module rbdi_ctrl
  import rbdi_pkg::*;
#(
  parameter int NUM_SLOTS = 2430,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxFrame,
  input  logic              insValid,
  input  logic              cfgWrEn,
  input  logic [SLOT_W-1:0] cfgWrSlot,
  input  logic              cfgWrDrop,
  output logic [SLOT_W-1:0] curSlot,
  output slot_strobe_t      strobe
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W:0]   SLOT_LIMIT = (SLOT_W + 1)'(NUM_SLOTS);

  logic [SLOT_W-1:0]    slotReg;
  logic [NUM_SLOTS-1:0] shadowTbl;
  logic [NUM_SLOTS-1:0] activeTbl;
  logic                 slotDrop;
  logic                 wrInRange;

  // Slot of the byte now on the bus: pulse forces 0, otherwise step and wrap.
  always_comb begin
    if (rxFrame)                curSlot = '0;
    else if (slotReg == LAST_SLOT) curSlot = '0;
    else                        curSlot = slotReg + 1'b1;
  end

  // On a pulse cycle the shadow table is already the one in force.
  assign slotDrop  = rxFrame ? shadowTbl[curSlot] : activeTbl[curSlot];
  assign wrInRange = {1'b0, cfgWrSlot} < SLOT_LIMIT;

  always_comb begin
    strobe.frame  = rxFrame;
    strobe.drop   = slotDrop;
    strobe.useIns = slotDrop & insValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotReg   <= LAST_SLOT;
      shadowTbl <= '0;
      activeTbl <= '0;
    end else begin
      slotReg <= curSlot;
      if (rxFrame) activeTbl <= shadowTbl;
      if (cfgWrEn && wrInRange) shadowTbl[cfgWrSlot] <= cfgWrDrop;
    end
  end
endmodule

// File: rtl/rbdi_datapath.sv
module rbdi_datapath
  import rbdi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 12,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_strobe_t      strobe,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] insData,
  input  logic [SLOT_W-1:0] curSlot,
  output logic [DATA_W-1:0] txData,
  output logic              txFrame,
  output logic [DATA_W-1:0] dropData,
  output logic              dropValid,
  output logic [SLOT_W-1:0] dropSlot
);
  logic [DATA_W-1:0] fillByte;
  logic [DATA_W-1:0] outByte;

  assign fillByte = strobe.useIns ? insData : IDLE_BYTE;
  assign outByte  = strobe.drop ? fillByte : rxData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData    <= IDLE_BYTE;
      txFrame   <= 1'b0;
      dropData  <= '0;
      dropValid <= 1'b0;
      dropSlot  <= '0;
    end else begin
      txData    <= outByte;
      txFrame   <= strobe.frame;
      dropData  <= strobe.drop ? rxData : '0;
      dropValid <= strobe.drop;
      dropSlot  <= curSlot;
    end
  end
endmodule

// File: rtl/ring_bypass_di.sv
module ring_bypass_di
  import rbdi_pkg::*;
#(
  parameter int NUM_SLOTS = 2430,
  parameter int DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxFrame,
  output logic [DATA_W-1:0] txData,
  output logic              txFrame,
  output logic [SLOT_W-1:0] curSlot,
  input  logic [DATA_W-1:0] insData,
  input  logic              insValid,
  output logic [DATA_W-1:0] dropData,
  output logic              dropValid,
  output logic [SLOT_W-1:0] dropSlot,
  input  logic              cfgWrEn,
  input  logic [SLOT_W-1:0] cfgWrSlot,
  input  logic              cfgWrDrop
);
  slot_strobe_t strobe;

  rbdi_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxFrame(rxFrame), .insValid(insValid),
    .cfgWrEn(cfgWrEn), .cfgWrSlot(cfgWrSlot), .cfgWrDrop(cfgWrDrop),
    .curSlot(curSlot), .strobe(strobe)
  );

  rbdi_datapath #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .IDLE_BYTE(IDLE_BYTE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData),
    .insData(insData), .curSlot(curSlot), .txData(txData),
    .txFrame(txFrame), .dropData(dropData), .dropValid(dropValid),
    .dropSlot(dropSlot)
  );
endmodule

// File: rtl/rbdi_checker.sv
module rbdi_checker #(
  parameter int NUM_SLOTS = 2430,
  parameter int DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFrame,
  input logic [DATA_W-1:0] txData,
  input logic              txFrame,
  input logic [SLOT_W-1:0] curSlot,
  input logic [DATA_W-1:0] insData,
  input logic              insValid,
  input logic [DATA_W-1:0] dropData,
  input logic              dropValid,
  input logic [SLOT_W-1:0] dropSlot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_TRANSIT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !dropValid |-> txData == $past(rxData));  // R1
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> txFrame == $past(rxFrame));  // R2
  AST_DROP_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && dropValid |-> dropData == $past(rxData) && dropSlot == $past(curSlot));  // R3
  AST_INSERT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && dropValid && $past(insValid) |-> txData == $past(insData));  // R4
  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && dropValid && !$past(insValid) |-> txData == IDLE_BYTE);  // R5
  AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rxFrame |-> curSlot == '0);  // R7
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !rxFrame |->
      curSlot == (($past(curSlot) == LAST_SLOT) ? '0 : $past(curSlot) + 1'b1));  // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !rstN |-> txData == IDLE_BYTE && !txFrame && !dropValid);  // R9
endmodule

bind ring_bypass_di rbdi_checker #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDLE_BYTE(IDLE_BYTE)
) u_chk (
  .clk(clk), .rstN(rstN), .rxData(rxData), .rxFrame(rxFrame),
  .txData(txData), .txFrame(txFrame), .curSlot(curSlot),
  .insData(insData), .insValid(insValid), .dropData(dropData),
  .dropValid(dropValid), .dropSlot(dropSlot)
);

// File: tb/tb_ring_bypass_di.sv
module tb_ring_bypass_di;
  localparam int NS = 12;
  localparam int DW = 8;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] rxData = '0, insData = '0;
  logic          rxFrame = 1'b0, insValid = 1'b0;
  logic          cfgWrEn = 1'b0, cfgWrDrop = 1'b0;
  logic [SW-1:0] cfgWrSlot = '0;
  logic [DW-1:0] txData, dropData;
  logic          txFrame, dropValid;
  logic [SW-1:0] curSlot, dropSlot;

  ring_bypass_di #(.NUM_SLOTS(NS), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxFrame(rxFrame),
    .txData(txData), .txFrame(txFrame), .curSlot(curSlot),
    .insData(insData), .insValid(insValid), .dropData(dropData),
    .dropValid(dropValid), .dropSlot(dropSlot), .cfgWrEn(cfgWrEn),
    .cfgWrSlot(cfgWrSlot), .cfgWrDrop(cfgWrDrop)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, n = 0, prevSlot = NS - 1;
  bit havePrev = 0, done = 0;
  bit [NS-1:0] shadowM = '0, activeM = '0;
  int expTx, expFrame, expDV, expDD, expDS;
  string txTag;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", tag, act, exp, n);
    end
  endtask

  task automatic cycle(bit fr, int rx, bit iv, int id, bit we, int ws, bit wd);
    int slot;
    bit drop;
    @(negedge clk);
    if (havePrev) begin
      check(txTag, txData, expTx);
      check("R2", txFrame, expFrame);
      check("R8", dropValid, expDV);
      check("R3", dropData, expDD);
      if (expDV != 0) check("R3", dropSlot, expDS);
    end
    rxFrame = fr; rxData = DW'(rx); insValid = iv; insData = DW'(id);
    cfgWrEn = we; cfgWrSlot = SW'(ws); cfgWrDrop = wd;
    #1;
    slot = fr ? 0 : ((prevSlot == NS - 1) ? 0 : prevSlot + 1);
    check("R7", curSlot, slot);
    drop = fr ? shadowM[slot] : activeM[slot];
    expTx    = drop ? (iv ? (id & 255) : 255) : (rx & 255);
    txTag    = drop ? (iv ? "R4" : "R5") : (iv ? "R6" : "R1");
    expFrame = fr;
    expDV    = drop;
    expDD    = drop ? (rx & 255) : 0;
    expDS    = slot;
    havePrev = 1;
    prevSlot = slot;
    if (fr) activeM = shadowM;
    if (we) shadowM[ws] = wd;
    n++;
  endtask

  // mode 0: no writes; 1: mark every third slot local; 2: rewrite offset slots;
  // 3: flip slot 0 in the pulse cycle itself
  task automatic runFrame(int len, bit pulse, int mode);
    for (int s = 0; s < len; s++) begin
      bit fr = pulse && (s == 0);
      int rx = (n * 37 + 11) & 255;
      bit iv = (mode == 3) ? ((n % 3) != 0) : n[0];
      int id = (n * 91 + 200) & 255;
      bit we = 0; int ws = 0; bit wd = 0;
      if (mode == 1) begin we = 1; ws = s % NS; wd = ((s % 3) == 0); end
      if (mode == 2) begin we = 1; ws = (s + 5) % NS; wd = s[0]; end
      if (mode == 3 && s == 0) begin we = 1; ws = 0; wd = !shadowM[0]; end
      cycle(fr, rx, iv, id, we, ws, wd);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", txData, 255);
    check("R9", txFrame, 0);
    check("R9", dropValid, 0);
    rstN = 1'b1;
    runFrame(NS, 1, 0);   // R9 all transit after reset
    runFrame(NS, 1, 0);
    runFrame(NS, 1, 1);   // R8 writes stay in shadow this frame
    runFrame(NS, 1, 0);   // R8 now active
    runFrame(7, 1, 0);    // R7 early pulse
    runFrame(NS, 1, 3);   // R8 pulse-cycle write deferred
    runFrame(NS, 1, 2);
    runFrame(NS, 1, 0);
    runFrame(30, 0, 0);   // R7 wrap without pulse
    runFrame(NS, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule